// File: doc/BRIEF.md
# System Exception State Register Block

This block holds the pending state of the fixed system exceptions and of the external interrupts, and gives software a word-wide register bus to raise, withdraw and inspect that state. The exceptions it tracks use these exception numbers: non-maskable interrupt 2, memory fault 4, bus fault 5, usage fault 6, service call 11, debug 12, pendable service 14 and tick 15. External interrupt k has exception number 16 + k. The core raises exceptions with a per-number request bitmap, and a timer raises the tick exception with a one-cycle pulse. The arbiter reports the active and highest-pending vectors, a bitmap of active system exceptions, and an acknowledge that retires a pending exception once it has been taken.

Software also gets a vector-table base register, a keyed reset-control register that produces one-cycle reset and clear-active requests, and a trigger register that makes one external interrupt pending by its index. Priority arbitration and vector fetch are handled outside this block. Registers sit at word addresses 0 (control/state), 1 (vector base), 2 (reset control), 3 (handler state) and 4 (trigger). Reads are combinational from `busAddr`.

Top module: `exc_status_regs`

## Requirements
- R1: A read of the control/state register returns the active vector in bits 8:0, the inverse of `priorActive` in bit 11, the pending vector in bits 20:12, the OR of all external pending bits in bit 22, tick pending in bit 26, pendable-service pending in bit 28 and non-maskable pending in bit 31. All other bits read as zero.
- R2: A write to the control/state register with bit 31 set makes the non-maskable exception pending. Bit 28 sets pendable-service pending; if bit 28 is clear, bit 27 clears it. Bit 26 sets tick pending; if bit 26 is clear, bit 25 clears it. Software cannot clear non-maskable pending.
- R3: A `tickPulse` makes tick pending, and `hwRaise[n]` makes exception n pending. Only numbers 2, 4, 5, 6, 11, 14 and 15 can pend, so `sysPending` never goes beyond mask 0xC874.
- R4: An acknowledge with `ackVec` = n clears the pending bit of system exception n, or of external interrupt n-16. A set request for the same bit in the same cycle wins over the acknowledge.
- R5: A write to the vector-base register keeps bits 31:7 of the data. Bits 6:0 read as zero.
- R6: The reset-control register reads 0xFA050000. A write whose bits 31:16 equal 0x05FA pulses `resetReq` for one cycle if bit 0 or bit 2 is set, and pulses `clrActive` if bit 1 is set. A write with any other key has no effect.
- R7: A read of the handler-state register returns active bits for memory 0, bus 1, usage 3, service call 7, debug 8, pendable service 10 and tick 11 (taken from `sysActive`). It returns pending bits for usage 12, memory 13, bus 14 and service call 15, and the fault enables for memory 16, bus 17 and usage 18.
- R8: Only bits 18:16 of a handler-state write are stored. They drive `faultEnable` as {usage, bus, memory}.
- R9: A trigger-register write makes external interrupt `wdata[8:0]` pending if that index is below NUM_EXT. Otherwise the write is ignored.
- R10: After reset every pending bit, enable, base and pulse output is zero. Unmapped addresses read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational from busAddr) |
| tickPulse | input | 1 | Timer request for the tick exception |
| hwRaise | input | 16 | Hardware pend request per system exception number |
| ackValid | input | 1 | Arbiter acknowledge strobe |
| ackVec | input | 9 | Exception number being acknowledged |
| activeVec | input | 9 | Currently active vector, 0 if none |
| pendVec | input | 9 | Highest pending vector, 0 if none |
| priorActive | input | 1 | Another exception is active beneath the current one |
| sysActive | input | 16 | Active bitmap of system exceptions |
| sysPending | output | 16 | Pending bitmap indexed by exception number |
| extPending | output | NUM_EXT | Pending bits of the external interrupts |
| faultEnable | output | 3 | Fault enables {usage, bus, memory} |
| vecBase | output | 32 | Vector-table base |
| resetReq | output | 1 | One-cycle system reset request |
| clrActive | output | 1 | One-cycle clear-active request |

## Verification
The bench targets the single-register set/clear pairs written with both bits at once. A design that gave priority to clear would drop a pending service call or tick that software meant to keep. It targets an acknowledge that lands in the same cycle as a tick pulse; a wrong design would lose that tick. It writes trigger indices at and above the implemented count, and an index with a bit set above bit 8. A design that failed to bound or truncate the index would set a wrong pending bit. It also sends reset-control writes with a wrong key, raises every hardware request line at once so that unimplemented numbers could leak into `sysPending`, and checks that the reset and clear-active requests last exactly one cycle.

// File: rtl/exc_status_pkg.sv
package exc_status_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int SYS_N    = 16;
  localparam int EXT_BASE = 16;
  localparam int TRIG_W   = 9;

  // Exception numbers (fixed by the surrounding core)
  localparam int EXC_NMI    = 2;
  localparam int EXC_MEM    = 4;
  localparam int EXC_BUS    = 5;
  localparam int EXC_USAGE  = 6;
  localparam int EXC_SVCALL = 11;
  localparam int EXC_DEBUG  = 12;
  localparam int EXC_PENDSV = 14;
  localparam int EXC_TICK   = 15;

  // Numbers that own a pending bit
  localparam logic [SYS_N-1:0] PEND_IMPL =
      SYS_N'((1 << EXC_NMI) | (1 << EXC_MEM) | (1 << EXC_BUS) | (1 << EXC_USAGE) |
             (1 << EXC_SVCALL) | (1 << EXC_PENDSV) | (1 << EXC_TICK));

  localparam logic [15:0]       RST_KEY     = 16'h05FA;
  localparam logic [DATA_W-1:0] RSTCTL_READ = 32'hFA05_0000;

  // Control/state register bit positions
  localparam int CS_PRIOR_BIT  = 11;
  localparam int CS_PEND_LSB   = 12;
  localparam int CS_EXTANY_BIT = 22;
  localparam int CS_CLRTICK    = 25;
  localparam int CS_SETTICK    = 26;
  localparam int CS_CLRPSV     = 27;
  localparam int CS_SETPSV     = 28;
  localparam int CS_SETNMI     = 31;

  // Handler-state register field
  localparam int HS_EN_LSB = 16;
  localparam int VB_LSB    = 7;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTLST   = 3'd0,
    REG_VECBASE = 3'd1,
    REG_RSTCTL  = 3'd2,
    REG_HANDLER = 3'd3,
    REG_TRIGGER = 3'd4
  } regSel_e;

  typedef struct packed {
    logic              setNmi;
    logic              setPendsv;
    logic              clrPendsv;
    logic              setTick;
    logic              clrTick;
    logic              loadVecBase;
    logic              loadFaultEn;
    logic              trigExt;
    logic [TRIG_W-1:0] trigIdx;
    logic              sysReset;
    logic              clrActive;
  } excStrobes_t;

endpackage

// File: rtl/exc_status_ctrl.sv
module exc_status_ctrl
  import exc_status_pkg::*;
#(
  parameter int NUM_EXT = 32
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output excStrobes_t       stb
);

  logic wrEn;
  logic keyOk;
  logic trigOk;
  logic [TRIG_W-1:0] idx;
  logic unusedCtl;

  assign wrEn   = busValid && busWrite;
  assign keyOk  = (busWdata[31:16] == RST_KEY);
  assign idx    = busWdata[TRIG_W-1:0];
  assign trigOk = (32'(idx) < NUM_EXT);
  assign unusedCtl = ^busWdata;

  always_comb begin
    stb = '0;
    stb.trigIdx = idx;
    if (wrEn) begin
      case (busAddr)
        REG_CTLST: begin
          stb.setNmi    = busWdata[CS_SETNMI];
          stb.setPendsv = busWdata[CS_SETPSV];
          stb.clrPendsv = busWdata[CS_CLRPSV] && !busWdata[CS_SETPSV];
          stb.setTick   = busWdata[CS_SETTICK];
          stb.clrTick   = busWdata[CS_CLRTICK] && !busWdata[CS_SETTICK];
        end
        REG_VECBASE: stb.loadVecBase = 1'b1;
        REG_RSTCTL: begin
          stb.sysReset  = keyOk && (busWdata[0] || busWdata[2]);
          stb.clrActive = keyOk && busWdata[1];
        end
        REG_HANDLER: stb.loadFaultEn = 1'b1;
        REG_TRIGGER: stb.trigExt     = trigOk;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/exc_status_dp.sv
module exc_status_dp
  import exc_status_pkg::*;
#(
  parameter int NUM_EXT = 32,
  parameter int VEC_W   = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  excStrobes_t        stb,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdata,
  input  logic               tickPulse,
  input  logic [SYS_N-1:0]   hwRaise,
  input  logic               ackValid,
  input  logic [VEC_W-1:0]   ackVec,
  input  logic [VEC_W-1:0]   activeVec,
  input  logic [VEC_W-1:0]   pendVec,
  input  logic               priorActive,
  input  logic [SYS_N-1:0]   sysActive,
  output logic [SYS_N-1:0]   sysPend,
  output logic [NUM_EXT-1:0] extPend,
  output logic [2:0]         faultEnQ,
  output logic [DATA_W-1:0]  vecBaseQ,
  output logic               resetReqQ,
  output logic               clrActiveQ
);

  logic [SYS_N-1:0]   sysSet, sysClr, sysAck;
  logic [NUM_EXT-1:0] extSet, extAck;
  logic [SYS_N-1:0]   swSet, swClr;

  // Acknowledge decode, one comparator per pending bit
  for (genvar i = 0; i < SYS_N; i++) begin : gSysAck
    assign sysAck[i] = ackValid && (ackVec == VEC_W'(i));
  end

  for (genvar k = 0; k < NUM_EXT; k++) begin : gExt
    assign extAck[k] = ackValid && (ackVec == VEC_W'(EXT_BASE + k));
    assign extSet[k] = stb.trigExt && (32'(stb.trigIdx) == k);
  end

  always_comb begin
    swSet = '0;
    swClr = '0;
    swSet[EXC_NMI]    = stb.setNmi;
    swSet[EXC_PENDSV] = stb.setPendsv;
    swSet[EXC_TICK]   = stb.setTick || tickPulse;
    swClr[EXC_PENDSV] = stb.clrPendsv;
    swClr[EXC_TICK]   = stb.clrTick;
  end

  assign sysSet = hwRaise | swSet;
  assign sysClr = sysAck | swClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sysPend    <= '0;
      extPend    <= '0;
      faultEnQ   <= '0;
      vecBaseQ   <= '0;
      resetReqQ  <= 1'b0;
      clrActiveQ <= 1'b0;
    end else begin
      sysPend    <= (sysSet | (sysPend & ~sysClr)) & PEND_IMPL;
      extPend    <= extSet | (extPend & ~extAck);
      resetReqQ  <= stb.sysReset;
      clrActiveQ <= stb.clrActive;
      if (stb.loadFaultEn) faultEnQ <= wdata[HS_EN_LSB +: 3];
      if (stb.loadVecBase) vecBaseQ <= {wdata[DATA_W-1:VB_LSB], {VB_LSB{1'b0}}};
    end
  end

  // Read mux
  logic [DATA_W-1:0] csWord, hsWord;

  always_comb begin
    csWord = '0;
    csWord[VEC_W-1:0]               = activeVec;
    csWord[CS_PRIOR_BIT]            = !priorActive;
    csWord[CS_PEND_LSB +: VEC_W]    = pendVec;
    csWord[CS_EXTANY_BIT]           = |extPend;
    csWord[CS_SETTICK]              = sysPend[EXC_TICK];
    csWord[CS_SETPSV]               = sysPend[EXC_PENDSV];
    csWord[CS_SETNMI]               = sysPend[EXC_NMI];
  end

  always_comb begin
    hsWord = '0;
    hsWord[0]  = sysActive[EXC_MEM];
    hsWord[1]  = sysActive[EXC_BUS];
    hsWord[3]  = sysActive[EXC_USAGE];
    hsWord[7]  = sysActive[EXC_SVCALL];
    hsWord[8]  = sysActive[EXC_DEBUG];
    hsWord[10] = sysActive[EXC_PENDSV];
    hsWord[11] = sysActive[EXC_TICK];
    hsWord[12] = sysPend[EXC_USAGE];
    hsWord[13] = sysPend[EXC_MEM];
    hsWord[14] = sysPend[EXC_BUS];
    hsWord[15] = sysPend[EXC_SVCALL];
    hsWord[HS_EN_LSB +: 3] = faultEnQ;
  end

  always_comb begin
    case (rdAddr)
      REG_CTLST:   rdata = csWord;
      REG_VECBASE: rdata = vecBaseQ;
      REG_RSTCTL:  rdata = RSTCTL_READ;
      REG_HANDLER: rdata = hsWord;
      default:     rdata = '0;
    endcase
  end

  logic unusedDp;
  assign unusedDp = ^{sysActive, wdata};

  // A set in the same cycle as an acknowledge still leaves the bit pending
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    tickPulse |=> sysPend[EXC_TICK]);

  // Acknowledge without a competing set clears the bit
  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ackValid && ackVec == VEC_W'(EXC_NMI) && !stb.setNmi && !hwRaise[EXC_NMI])
      |=> !sysPend[EXC_NMI]);

  // At most one external bit becomes pending per cycle
  assert_ext_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(extPend) <= $countones($past(extPend)) + 1));

  // Fault enables change only on a handler-state write
  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadFaultEn |=> $stable(faultEnQ));

endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
  import exc_status_pkg::*;
#(
  parameter int NUM_EXT = 32,
  parameter int VEC_W   = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [2:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic               tickPulse,
  input  logic [15:0]        hwRaise,
  input  logic               ackValid,
  input  logic [VEC_W-1:0]   ackVec,
  input  logic [VEC_W-1:0]   activeVec,
  input  logic [VEC_W-1:0]   pendVec,
  input  logic               priorActive,
  input  logic [15:0]        sysActive,
  output logic [15:0]        sysPending,
  output logic [NUM_EXT-1:0] extPending,
  output logic [2:0]         faultEnable,
  output logic [31:0]        vecBase,
  output logic               resetReq,
  output logic               clrActive
);

  excStrobes_t stb;

  exc_status_ctrl #(.NUM_EXT(NUM_EXT)) uCtrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .stb      (stb)
  );

  exc_status_dp #(.NUM_EXT(NUM_EXT), .VEC_W(VEC_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wdata       (busWdata),
    .rdAddr      (busAddr),
    .rdata       (busRdata),
    .tickPulse   (tickPulse),
    .hwRaise     (hwRaise),
    .ackValid    (ackValid),
    .ackVec      (ackVec),
    .activeVec   (activeVec),
    .pendVec     (pendVec),
    .priorActive (priorActive),
    .sysActive   (sysActive),
    .sysPend     (sysPending),
    .extPend     (extPending),
    .faultEnQ    (faultEnable),
    .vecBaseQ    (vecBase),
    .resetReqQ   (resetReq),
    .clrActiveQ  (clrActive)
  );

  assert_vecbase_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && busAddr == REG_VECBASE)
      |=> (vecBase[31:VB_LSB] == $past(busWdata[31:VB_LSB])));

  assert_reset_key_R6: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> $past(busValid && busWrite && busAddr == REG_RSTCTL &&
                       busWdata[31:16] == RST_KEY));

endmodule

// File: tb/tb_exc_status_regs.sv
module tb_exc_status_regs;

  localparam int  CLK_PERIOD = 10;
  localparam int  NUM_EXT    = 32;
  localparam int  VEC_W      = 9;
  localparam int  ROWS       = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic tickPulse = 1'b0;
  logic [15:0] hwRaise = '0;
  logic ackValid = 1'b0;
  logic [VEC_W-1:0] ackVec = '0, activeVec = '0, pendVec = '0;
  logic priorActive = 1'b0;
  logic [15:0] sysActive = '0;
  logic [15:0] sysPending;
  logic [NUM_EXT-1:0] extPending;
  logic [2:0] faultEnable;
  logic [31:0] vecBase;
  logic resetReq, clrActive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_status_regs #(.NUM_EXT(NUM_EXT), .VEC_W(VEC_W)) dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickPulse(tickPulse), .hwRaise(hwRaise), .ackValid(ackValid),
    .ackVec(ackVec), .activeVec(activeVec), .pendVec(pendVec),
    .priorActive(priorActive), .sysActive(sysActive),
    .sysPending(sysPending), .extPending(extPending),
    .faultEnable(faultEnable), .vecBase(vecBase),
    .resetReq(resetReq), .clrActive(clrActive)
  );

  // {tag, write addr, write data, read addr, expected read}
  localparam logic [93:0] TBL [ROWS] = '{
    {"R2 ", 3'd0, 32'h8000_0000, 3'd0, 32'h8000_0800},
    {"R2 ", 3'd0, 32'h1000_0000, 3'd0, 32'h9000_0800},
    {"R2 ", 3'd0, 32'h0800_0000, 3'd0, 32'h8000_0800},
    {"R2 ", 3'd0, 32'h1800_0000, 3'd0, 32'h9000_0800},
    {"R2 ", 3'd0, 32'h0400_0000, 3'd0, 32'h9400_0800},
    {"R2 ", 3'd0, 32'h0600_0000, 3'd0, 32'h9400_0800},
    {"R2 ", 3'd0, 32'h0200_0000, 3'd0, 32'h9000_0800},
    {"R2 ", 3'd0, 32'h0000_0000, 3'd0, 32'h9000_0800},
    {"R5 ", 3'd1, 32'hFFFF_FFFF, 3'd1, 32'hFFFF_FF80},
    {"R5 ", 3'd1, 32'h2000_00FF, 3'd1, 32'h2000_0080},
    {"R8 ", 3'd3, 32'hFFFF_FFFF, 3'd3, 32'h0007_0000},
    {"R8 ", 3'd3, 32'h0002_0000, 3'd3, 32'h0002_0000},
    {"R9 ", 3'd4, 32'h0000_0005, 3'd0, 32'h9040_0800},
    {"R6 ", 3'd2, 32'h1234_0004, 3'd2, 32'hFA05_0000},
    {"R10", 3'd7, 32'hFFFF_FFFF, 3'd7, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Ends one time unit after the capturing edge
  task automatic busWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic ack(input int v, input logic withTick);
    @(negedge clk);
    ackValid = 1'b1; ackVec = VEC_W'(v); tickPulse = withTick;
    @(posedge clk); #1;
    ackValid = 1'b0; tickPulse = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    logic [93:0] row;
    repeat (3) @(posedge clk);
    #1;
    // Reset state
    check("R10", {16'b0, sysPending}, 32'h0);
    check("R10", extPending, 32'h0);
    check("R10", {29'b0, faultEnable}, 32'h0);
    check("R10", vecBase, 32'h0);
    check("R10", {30'b0, resetReq, clrActive}, 32'h0);
    busRd(3'd0, rd); check("R1", rd, 32'h0000_0800);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < ROWS; i++) begin
      row = TBL[i];
      busWr(row[69:67], row[66:35]);
      busRd(row[34:32], rd);
      check(string'(row[93:70]), rd, row[31:0]);
    end
    busRd(3'd0, rd); check("R10", rd, 32'h9040_0800);
    check("R8", {29'b0, faultEnable}, 32'h2);
    check("R5", vecBase, 32'h2000_0080);
    check("R6", {30'b0, resetReq, clrActive}, 32'h0);

    // Trigger bounds and index truncation
    check("R9", extPending, 32'h0000_0020);
    busWr(3'd4, 32'd32);          check("R9", extPending, 32'h0000_0020);
    busWr(3'd4, 32'h0000_01FF);   check("R9", extPending, 32'h0000_0020);
    busWr(3'd4, 32'h0000_0203);   check("R9", extPending, 32'h0000_0028);
    busWr(3'd4, 32'd31);          check("R9", extPending, 32'h8000_0028);

    // Acknowledge
    ack(21, 1'b0); check("R4", extPending, 32'h8000_0008);
    ack(14, 1'b0); check("R4", {16'b0, sysPending}, 32'h0000_0004);
    ack(3, 1'b0);  check("R4", {16'b0, sysPending}, 32'h0000_0004);

    // Tick pulse, and tick racing its own acknowledge
    @(negedge clk); tickPulse = 1'b1; @(posedge clk); #1; tickPulse = 1'b0;
    check("R3", {16'b0, sysPending}, 32'h0000_8004);
    ack(15, 1'b1); check("R4", {16'b0, sysPending}, 32'h0000_8004);
    ack(15, 1'b0); check("R4", {16'b0, sysPending}, 32'h0000_0004);

    // All hardware requests at once
    @(negedge clk); hwRaise = 16'hFFFF; @(posedge clk); #1; hwRaise = '0;
    check("R3", {16'b0, sysPending}, 32'h0000_C874);
    busRd(3'd3, rd); check("R7", rd, 32'h0002_F000);
    sysActive = 16'hFFFF;
    busRd(3'd3, rd); check("R7", rd, 32'h0002_FD8B);
    sysActive = 16'h0000;

    // Status fields from the arbiter
    activeVec = 9'h1A3; pendVec = 9'h025; priorActive = 1'b1;
    busRd(3'd0, rd); check("R1", rd, 32'h9442_51A3);
    activeVec = '0; pendVec = '0; priorActive = 1'b0;
    busRd(3'd0, rd); check("R1", rd, 32'h9440_0800);

    // Keyed reset control
    busWr(3'd2, 32'h05FA_0004);
    check("R6", {30'b0, resetReq, clrActive}, 32'h2);
    @(posedge clk); #1;
    check("R6", {30'b0, resetReq, clrActive}, 32'h0);
    busWr(3'd2, 32'h05FA_0002);
    check("R6", {30'b0, resetReq, clrActive}, 32'h1);
    busWr(3'd2, 32'h05FB_0007);
    check("R6", {30'b0, resetReq, clrActive}, 32'h0);
    busWr(3'd2, 32'h05FA_0001);
    check("R6", {30'b0, resetReq, clrActive}, 32'h2);

    // Reset mid-run
    @(negedge clk); rstN = 1'b0;
    #1;
    check("R10", {16'b0, sysPending}, 32'h0);
    check("R10", extPending, 32'h0);
    check("R10", vecBase, 32'h0);
    check("R10", {27'b0, faultEnable, resetReq, clrActive}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (R1..all): actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule